// File: doc/BRIEF.md
# Upstream Read Request Splitter

The block sits between a memory-mapped read port and a link-layer request generator. A master presents one read burst at a time: a byte address, a beat count (one beat is one dword), and a 4-bit byte enable. The burst may span up to 4 KB and start anywhere. The block breaks the burst into a series of read request descriptors. Each descriptor carries an address, a length in dwords, first and last byte enables, an address-format flag and a tag.

A descriptor ends at whichever comes first: the end of the burst, the 256-byte size cap, or the next 4 KB address boundary. The 64-bit format flag is set per descriptor from that descriptor's own address. Each issued descriptor takes the next tag from a wrapping counter. Issue waits while every tag is outstanding, and a tag is returned by pulsing the release input.

An illegal burst is not split. It yields one descriptor with its error flag set, so that the request can be answered with an abort completion.

Top module: `rd_req_splitter`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_valid_o` is 0. A burst is taken on a cycle where both `in_valid_i` and `in_ready_o` are high. `in_ready_o` then stays low until the last descriptor of that burst has been accepted.
- R2: Every non-error descriptor has a `out_len_o` of at least 1 and at most 64 dwords (256 bytes).
- R3: Every non-error descriptor has a length equal to the minimum of three values: the dwords left in the burst, 64, and the dwords up to the next 4 KB boundary. Descriptors come out in address order, and each one starts where the previous one ended.
- R4: `out_fmt64_o` is 1 exactly when bits 63:32 of that descriptor's `out_addr_o` are not all zero.
- R5: A descriptor of one dword has `out_last_be_o` = 0. Its `out_first_be_o` is the burst's `in_be_i` when the burst has a single beat, and 4'hF otherwise. A longer descriptor has both enables at 4'hF. Bit i of an enable stands for byte i of the dword.
- R6: A burst is illegal when any of these holds: its beat count is 0; its beat count is above 1024; its beat count is above 1 and `in_be_i` is not 4'hF; or address bits 1:0 are not zero. An illegal burst gives exactly one descriptor with `out_err_o` = 1, length 0, both enables 0 and the burst's address. That descriptor consumes no tag and does not wait for a free tag.
- R7: `out_tag_o` is 0 after reset. It advances by one, modulo 32, for each accepted non-error descriptor.
- R8: The count of outstanding tags rises by one per accepted non-error descriptor and falls by one per `tag_release_i` pulse. While 32 tags are outstanding, no non-error descriptor is offered. An accepted descriptor and a release in the same cycle leave the count unchanged.
- R9: Once offered, a descriptor stays valid and unchanged until `out_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Read burst present |
| in_ready_o | output | 1 | Burst can be taken |
| in_addr_i | input | 64 | Burst byte address |
| in_bcnt_i | input | 11 | Burst length in dword beats |
| in_be_i | input | 4 | Burst byte enables |
| out_valid_o | output | 1 | Descriptor offered |
| out_ready_i | input | 1 | Descriptor accepted |
| out_addr_o | output | 64 | Descriptor byte address |
| out_len_o | output | 7 | Descriptor length in dwords |
| out_first_be_o | output | 4 | First dword byte enables |
| out_last_be_o | output | 4 | Last dword byte enables |
| out_fmt64_o | output | 1 | 64-bit address format |
| out_tag_o | output | 5 | Request tag |
| out_err_o | output | 1 | Illegal burst, abort needed |
| tag_release_i | input | 1 | Returns one outstanding tag |

## Verification
A tag release can arrive in the same cycle as a descriptor is accepted, and both act on the outstanding count together. The bench lets tags pile up with releases held off, then enables random releases alongside random `out_ready_i`, so these coincidences occur repeatedly around the full mark. The bench tracks its own outstanding count and judges every cycle: `out_valid_o` must match whether a tag is free, and the tag value must match the bench's own counter. At the end it confirms that both a full stall and a same-cycle issue-and-release were actually hit.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} rrs_state_e;
  localparam int unsigned DW_BYTES = 4;
endpackage

// File: rtl/rrs_legal.sv
module rrs_legal #(
  parameter int unsigned BCNT_W    = 11,
  parameter int unsigned MAX_BEATS = 1024
) (
  input  logic [1:0]        addr_lo_i,
  input  logic [BCNT_W-1:0] bcnt_i,
  input  logic [3:0]        be_i,
  output logic              bad_o
);
  always_comb begin
    bad_o = 1'b0;
    if (bcnt_i == '0)                            bad_o = 1'b1;
    if (32'(bcnt_i) > MAX_BEATS)                 bad_o = 1'b1;
    if (bcnt_i != BCNT_W'(1) && be_i != 4'hF)    bad_o = 1'b1;
    if (addr_lo_i != 2'b00)                      bad_o = 1'b1;
  end
endmodule

// File: rtl/rrs_chunk.sv
module rrs_chunk #(
  parameter int unsigned OFF_W     = 10,
  parameter int unsigned REM_W     = 11,
  parameter int unsigned LEN_W     = 7,
  parameter int unsigned MAX_RD_DW = 64
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [REM_W-1:0] rem_i,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned W = (REM_W > OFF_W + 1) ? REM_W : OFF_W + 1;

  logic [W-1:0] to_bound, rem_x, cap, pick;

  always_comb begin
    to_bound = W'(1 << OFF_W) - W'(off_i);
    rem_x    = W'(rem_i);
    cap      = W'(MAX_RD_DW);
    pick     = (rem_x < cap) ? rem_x : cap;
    if (to_bound < pick) pick = to_bound;
    len_o    = LEN_W'(pick);
  end
endmodule

// File: rtl/rrs_tag_pool.sv
module rrs_tag_pool #(
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             release_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             avail_o
);
  localparam int unsigned NUM_TAGS = 1 << TAG_W;

  logic [TAG_W:0]   cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic             dec;

  assign dec     = release_i && (cnt_q != '0);
  assign avail_o = 32'(cnt_q) < NUM_TAGS;
  assign tag_o   = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      if (issue_i && !dec)      cnt_q <= cnt_q + 1'b1;
      else if (!issue_i && dec) cnt_q <= cnt_q - 1'b1;
      if (issue_i) tag_q <= tag_q + 1'b1;
    end
  end

  // R8
  issue_while_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> avail_o);

  // R8
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= NUM_TAGS);
endmodule

// File: rtl/rd_req_splitter.sv
module rd_req_splitter #(
  parameter int unsigned ADDR_W          = 64,
  parameter int unsigned BCNT_W          = 11,
  parameter int unsigned TAG_W           = 5,
  parameter int unsigned MAX_RD_BYTES    = 256,
  parameter int unsigned BOUND_BYTES     = 4096,
  parameter int unsigned MAX_BURST_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [BCNT_W-1:0] in_bcnt_i,
  input  logic [3:0]        in_be_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [6:0]        out_len_o,
  output logic [3:0]        out_first_be_o,
  output logic [3:0]        out_last_be_o,
  output logic              out_fmt64_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic              out_err_o,
  input  logic              tag_release_i
);
  import rrs_pkg::*;

  localparam int unsigned MAX_RD_DW = MAX_RD_BYTES / DW_BYTES;
  localparam int unsigned BOUND_DW  = BOUND_BYTES / DW_BYTES;
  localparam int unsigned MAX_BEATS = MAX_BURST_BYTES / DW_BYTES;
  localparam int unsigned LEN_W     = $clog2(MAX_RD_DW + 1);
  localparam int unsigned OFF_W     = $clog2(BOUND_DW);
  localparam int unsigned REM_W     = $clog2(MAX_BEATS + 1);

  rrs_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;
  logic [3:0]        be_q;
  logic              err_q;

  logic              bad, tag_avail, fire, issue, last;
  logic [LEN_W-1:0]  chunk_len;
  logic [TAG_W-1:0]  tag;

  rrs_legal #(.BCNT_W(BCNT_W), .MAX_BEATS(MAX_BEATS)) u_legal (
    .addr_lo_i (in_addr_i[1:0]),
    .bcnt_i    (in_bcnt_i),
    .be_i      (in_be_i),
    .bad_o     (bad)
  );

  rrs_chunk #(.OFF_W(OFF_W), .REM_W(REM_W), .LEN_W(LEN_W), .MAX_RD_DW(MAX_RD_DW)) u_chunk (
    .off_i (addr_q[OFF_W+1:2]),
    .rem_i (rem_q),
    .len_o (chunk_len)
  );

  rrs_tag_pool #(.TAG_W(TAG_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue),
    .release_i (tag_release_i),
    .tag_o     (tag),
    .avail_o   (tag_avail)
  );

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_BUSY) && (err_q || tag_avail);
  assign fire        = out_valid_o && out_ready_i;
  assign issue       = fire && !err_q;
  assign last        = err_q || (rem_q == REM_W'(chunk_len));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      be_q    <= '0;
      err_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (in_valid_i) begin
        state_q <= ST_BUSY;
        addr_q  <= in_addr_i;
        rem_q   <= bad ? '0 : REM_W'(in_bcnt_i);
        be_q    <= in_be_i;
        err_q   <= bad;
      end
    end else if (fire) begin
      if (last) state_q <= ST_IDLE;
      else begin
        addr_q <= addr_q + {{(ADDR_W-LEN_W-2){1'b0}}, chunk_len, 2'b00};
        rem_q  <= rem_q - REM_W'(chunk_len);
      end
    end
  end

  assign out_addr_o     = addr_q;
  assign out_len_o      = err_q ? '0 : 7'(chunk_len);
  assign out_first_be_o = err_q ? 4'h0 : be_q;
  assign out_last_be_o  = (err_q || chunk_len == LEN_W'(1)) ? 4'h0 : 4'hF;
  assign out_fmt64_o    = |addr_q[ADDR_W-1:32];
  assign out_tag_o      = tag;
  assign out_err_o      = err_q;

  // R2
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_err_o |-> out_len_o != '0 && 32'(out_len_o) <= MAX_RD_DW);

  // R3
  no_cross_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_err_o |->
      (32'(out_addr_o[OFF_W+1:2]) + 32'(out_len_o)) <= BOUND_DW);

  // R1
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o)
      && $stable(out_len_o) && $stable(out_tag_o));
endmodule

// File: tb/rd_req_splitter_bench.sv
`timescale 1ns/1ps
module rd_req_splitter_bench;
  localparam int NT = 32;
  localparam int NB = 400;
  localparam int WD = 150000;

  typedef struct {
    logic [63:0] addr;
    int          len;
    logic [3:0]  fb;
    logic [3:0]  lb;
    logic        f64;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [10:0] in_bcnt = '0;
  logic [3:0]  in_be = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_addr;
  logic [6:0]  out_len;
  logic [3:0]  out_fb, out_lb;
  logic        out_f64, out_err;
  logic [4:0]  out_tag;
  logic        rel = 1'b0;

  always #5 clk = ~clk;

  rd_req_splitter u_rd_req_splitter (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_addr_i(in_addr), .in_bcnt_i(in_bcnt), .in_be_i(in_be),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_addr_o(out_addr), .out_len_o(out_len),
    .out_first_be_o(out_fb), .out_last_be_o(out_lb),
    .out_fmt64_o(out_f64), .out_tag_o(out_tag), .out_err_o(out_err),
    .tag_release_i(rel)
  );

  int checks = 0, fails = 0;
  exp_t q[$];
  int exp_out = 0;
  logic [4:0] exp_tag = '0;
  int stall_seen = 0, coincide_seen = 0;

  task automatic chk(input logic ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic is_bad(input logic [63:0] a, input int bc, input logic [3:0] be);
    return (bc == 0) || (bc > 1024) || (bc != 1 && be != 4'hF) || (a[1:0] != 2'b00);
  endfunction

  task automatic push_burst(input logic [63:0] a, input int bc, input logic [3:0] be);
    exp_t e;
    if (is_bad(a, bc, be)) begin
      e.addr = a; e.len = 0; e.fb = 0; e.lb = 0; e.f64 = (a[63:32] != 0); e.err = 1;
      q.push_back(e);
    end else begin
      logic [63:0] cur = a;
      int rem = bc;
      while (rem > 0) begin
        int to_b = (4096 - int'(cur[11:0])) / 4;
        int n = rem;
        if (n > 64) n = 64;
        if (n > to_b) n = to_b;
        e.addr = cur; e.len = n; e.err = 0;
        e.f64 = (cur[63:32] != 0);
        e.fb = (n == 1) ? ((bc == 1) ? be : 4'hF) : 4'hF;
        e.lb = (n == 1) ? 4'h0 : 4'hF;
        q.push_back(e);
        cur = cur + 64'(n * 4);
        rem = rem - n;
      end
    end
  endtask

  task automatic gen(input int i, output logic [63:0] a, output int bc, output logic [3:0] be);
    logic [31:0] lo, hi;
    int r;
    be = 4'hF;
    case (i)
      0:  begin a = 64'h0;              bc = 1;    be = 4'b0110; end
      1:  begin a = 64'hFFC;            bc = 2;    end
      2:  begin a = 64'hF00;            bc = 128;  end
      3:  begin a = 64'h1_0000_0F80;    bc = 1024; end
      4:  begin a = 64'hFFFF_FFC0;      bc = 32;   end
      5:  begin a = 64'h100;            bc = 0;    end
      6:  begin a = 64'h200;            bc = 1025; end
      7:  begin a = 64'h300;            bc = 4;    be = 4'h7; end
      8:  begin a = 64'h102;            bc = 1;    end
      9:  begin a = 64'h40;             bc = 1024; end
      10: begin a = 64'h2000;           bc = 1;    be = 4'h0; end
      default: begin
        r  = int'($urandom % 32);
        lo = $urandom; hi = ($urandom % 2 != 0) ? $urandom : 32'h0;
        a  = {hi, lo[31:2], 2'b00};
        bc = 1 + int'($urandom % 1024);
        if (r < 4) bc = 1 + int'($urandom % 4);
        if (bc == 1) be = 4'($urandom);
        if (r == 29) a[1:0] = 2'($urandom % 3 + 1);
        if (r == 30) begin bc = 2 + int'($urandom % 100); be = 4'($urandom % 15); end
        if (r == 31) bc = ($urandom % 2 != 0) ? 0 : 1025 + int'($urandom % 1000);
      end
    endcase
  endtask

  initial begin
    int cyc = 0, bi = 0;
    logic prev_hold = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    // R7 tag after reset
    chk(out_tag == 5'd0, "R7", longint'(out_tag), 0);
    rst_n = 1'b1;
    while ((bi < NB || q.size() != 0) && cyc < WD) begin
      logic exp_v, fire, do_rel;
      @(negedge clk);
      cyc++;
      // R1
      chk(in_ready == (q.size() == 0), "R1", longint'(in_ready), longint'(q.size() == 0));
      exp_v = (q.size() != 0) && (q[0].err || exp_out < NT);
      // R8
      chk(out_valid == exp_v, "R8", longint'(out_valid), longint'(exp_v));
      if (q.size() != 0 && !q[0].err && exp_out == NT) stall_seen++;
      // R9
      if (prev_hold) chk(out_valid == 1'b1, "R9", longint'(out_valid), 1);
      if (out_valid && exp_v) begin
        chk(out_addr == q[0].addr, "R3", longint'(out_addr), longint'(q[0].addr));
        chk(int'(out_len) == q[0].len, "R3", longint'(out_len), longint'(q[0].len));
        if (!q[0].err) chk(out_len >= 1 && out_len <= 64, "R2", longint'(out_len), 64);
        chk(out_f64 == q[0].f64, "R4", longint'(out_f64), longint'(q[0].f64));
        chk(out_fb == q[0].fb && out_lb == q[0].lb, "R5",
            longint'({out_fb, out_lb}), longint'({q[0].fb, q[0].lb}));
        chk(out_err == q[0].err, "R6", longint'(out_err), longint'(q[0].err));
        chk(out_tag == exp_tag, "R7", longint'(out_tag), longint'(exp_tag));
      end
      out_ready = ($urandom % 4 != 0);
      fire = out_valid && out_ready;
      prev_hold = out_valid && !out_ready;
      do_rel = ((cyc % 512) >= 384) && ($urandom % 4 != 0) && (exp_out > 0);
      rel = do_rel;
      if (fire && exp_v) begin
        if (!q[0].err) begin
          exp_out++;
          exp_tag = exp_tag + 5'd1;
          if (do_rel) coincide_seen++;
        end
        void'(q.pop_front());
      end
      if (do_rel) exp_out--;
      in_valid = 1'b0;
      if (in_ready && bi < NB && ($urandom % 4 != 0)) begin
        logic [63:0] a; int bc; logic [3:0] be;
        gen(bi, a, bc, be);
        in_valid = 1'b1; in_addr = a; in_bcnt = 11'(bc); in_be = be;
        push_burst(a, bc, be);
        bi++;
      end
    end
    if (cyc >= WD) chk(1'b0, "watchdog", longint'(cyc), WD);
    // R8 coverage of full stall and coincident issue/release
    chk(stall_seen > 0, "R8", longint'(stall_seen), 1);
    chk(coincide_seen > 0, "R8", longint'(coincide_seen), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule